// File: doc/BRIEF.md
# Pointer-Indirect Word Copy Engine

This block moves one 32-bit word through a pair of pointers that themselves live in memory. The caller passes two references, each the address of a pointer word. The engine fetches both pointers, reads the word the source pointer names, and writes it where the destination pointer names. It can then store advanced pointer values back through the same references, so that repeated starts walk through a buffer.

The pointer update depends on a 2-bit mode. Memory-to-memory advances both sides. Port-to-memory keeps the source fixed and advances the destination. Memory-to-port advances the source and keeps the destination fixed. A fourth setting copies without touching either pointer. Every access uses a single synchronous memory port that is held until the memory signals ready.

Top module: `ptr_word_mover`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, and `mem_req` stays 0 whenever `busy` is 0.
- R2: A `go` pulse while idle performs reads in this order: at `src_ref`, at `dst_ref`, and at the source pointer just read. It then performs a write of that data word at the destination pointer. Reads have `mem_we`=0 and writes have `mem_we`=1.
- R3: Mode 0 (memory-to-memory) is followed by two writes, in this order: source pointer + 4 to `src_ref`, then destination pointer + 4 to `dst_ref`. That makes 3 writes in total.
- R4: Mode 1 (port-to-memory) writes back only destination pointer + 4 to `dst_ref`. The word at `src_ref` is unchanged.
- R5: Mode 2 (memory-to-port) writes back only source pointer + 4 to `src_ref`. The word at `dst_ref` is unchanged.
- R6: Mode 3 performs the data copy and no pointer write-back, which makes a single write.
- R7: The pointer increment wraps modulo 2^32, so a pointer of 0xFFFFFFFC is written back as 0x00000000.
- R8: An access completes only on a cycle with `mem_rdy`=1. While it waits, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady. An operation with N accesses and L wait cycles per access keeps `busy` high for N*(L+1)+1 cycles.
- R9: `done` is high for exactly one cycle, after the last access completes. `busy` is 0 in the following cycle.
- R10: A `go` pulse while `busy` is 1 is ignored. It starts no extra access and does not change the running transfer.
- R11: `mode`, `src_ref` and `dst_ref` are captured on the starting `go`. Changing them while busy does not alter the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse |
| mode | input | 2 | Pointer update mode (0 both, 1 destination, 2 source, 3 none) |
| src_ref | input | 32 | Address of the source pointer |
| dst_ref | input | 32 | Address of the destination pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the current access |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when `mem_rdy` is 1 |
| mem_rdy | input | 1 | Access completes on this cycle |

## Verification
Each of the four modes is run against the same kind of memory image. Comparing the write counts and the final reference words separates the modes, which differ only in which pointers come back advanced. A pointer at 0xFFFFFFFC exposes any increment that saturates or carries instead of wrapping. A memory that inserts wait states tells an engine that holds its request apart from one that advances early, and the busy-cycle count shows whether an access slips by a cycle. A second `go` pulse and input changes during a transfer show whether the operands are captured only once.

// File: rtl/ptr_word_mover.sv
module ptr_word_mover #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] src_ref,
  input  logic [AW-1:0] dst_ref,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rdy
);
  typedef enum logic [2:0] {
    S_IDLE, S_RSP, S_RDP, S_RDAT, S_WDAT, S_WSP, S_WDP, S_FIN
  } st_t;

  localparam logic [AW-1:0] INC = AW'(STEP);

  st_t           st;
  logic [1:0]    mode_q;
  logic [AW-1:0] sref_q, dref_q, sp, dp, word;

  wire adv_s = (mode_q == 2'd0) || (mode_q == 2'd2);
  wire adv_d = (mode_q == 2'd0) || (mode_q == 2'd1);
  wire ack   = mem_req && mem_rdy;

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign mem_req = busy && !done;
  assign mem_we  = (st == S_WDAT) || (st == S_WSP) || (st == S_WDP);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RSP:  mem_addr = sref_q;
      S_RDP:  mem_addr = dref_q;
      S_RDAT: mem_addr = sp;
      S_WDAT: begin mem_addr = dp;     mem_wdata = word;     end
      S_WSP:  begin mem_addr = sref_q; mem_wdata = sp + INC; end
      S_WDP:  begin mem_addr = dref_q; mem_wdata = dp + INC; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= '0;
      sref_q <= '0;
      dref_q <= '0;
      sp     <= '0;
      dp     <= '0;
      word   <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          mode_q <= mode;
          sref_q <= src_ref;
          dref_q <= dst_ref;
          st     <= S_RSP;
        end
        S_RSP:  if (ack) begin sp   <= mem_rdata; st <= S_RDP;  end
        S_RDP:  if (ack) begin dp   <= mem_rdata; st <= S_RDAT; end
        S_RDAT: if (ack) begin word <= mem_rdata; st <= S_WDAT; end
        S_WDAT: if (ack) st <= adv_s ? S_WSP : (adv_d ? S_WDP : S_FIN);
        S_WSP:  if (ack) st <= adv_d ? S_WDP : S_FIN;
        S_WDP:  if (ack) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ptr_word_mover_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [AW-1:0] src_ref,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_rdy
);
  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_we && mem_addr == $past(src_ref)));

  // R10
  start_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
endmodule

bind ptr_word_mover ptr_word_mover_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .src_ref(src_ref), .busy(busy),
  .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdy(mem_rdy)
);

// File: tb/sim_ptr_word_mover.sv
module sim_ptr_word_mover;
  logic        clk = 0, rst_n = 0, go = 0;
  logic [1:0]  mode = 0;
  logic [31:0] src_ref = 0, dst_ref = 0;
  logic        busy, done, mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  ptr_word_mover u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .src_ref(src_ref),
    .dst_ref(dst_ref), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  logic [31:0] mem [256];
  int          lat = 0, wcnt = 0;
  logic        clr_log = 0, pl_en = 0;
  logic [7:0]  pl_idx = 0;
  logic [31:0] pl_dat = 0;
  logic [31:0] alog [16];
  logic [15:0] wlog;
  int          an = 0, wn = 0, bcnt = 0;
  logic        pw = 0, unstable = 0;
  logic [31:0] pa, pd;
  logic        pwe;

  assign mem_rdy   = mem_req && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_dat;
    if (clr_log) begin
      an <= 0; wn <= 0; bcnt <= 0; wcnt <= 0; pw <= 0; unstable <= 0;
    end else begin
      if (busy) bcnt <= bcnt + 1;
      if (pw && (!mem_req || mem_addr != pa || mem_we != pwe || mem_wdata != pd))
        unstable <= 1;
      pw <= mem_req && !mem_rdy;
      pa <= mem_addr; pwe <= mem_we; pd <= mem_wdata;
      if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_rdy) begin
        if (an < 16) begin alog[an] <= mem_addr; wlog[an] <= mem_we; end
        an <= an + 1;
        if (mem_we) begin
          wn <= wn + 1;
          mem[mem_addr[9:2]] <= mem_wdata;
        end
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); pl_en = 1; pl_idx = a[9:2]; pl_dat = d;
    @(negedge clk); pl_en = 0;
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input logic [1:0] m);
    int n = 0;
    @(negedge clk); clr_log = 1;
    @(negedge clk); clr_log = 0;
    src_ref = s; dst_ref = d; mode = m; go = 1;
    @(negedge clk); go = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] sp, input logic [31:0] dp, input logic [31:0] w);
    put(32'h40, sp); put(32'h44, dp); put(sp, w); put(dp, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_mode0;
    setup(32'h100, 32'h200, 32'hCAFE0001);
    run(32'h40, 32'h44, 2'd0);
    chk("R2 addr0", alog[0], 32'h40);
    chk("R2 addr1", alog[1], 32'h44);
    chk("R2 addr2", alog[2], 32'h100);
    chk("R2 addr3", alog[3], 32'h200);
    chk("R2 reads", {29'b0, wlog[0], wlog[1], wlog[2]}, 0);
    chk("R2 data", mem[8'h80], 32'hCAFE0001);
    chk("R3 order", alog[4], 32'h40);
    chk("R3 order2", alog[5], 32'h44);
    chk("R3 srcptr", mem[8'h10], 32'h104);
    chk("R3 dstptr", mem[8'h11], 32'h204);
    chk("R3 writes", wn, 3);
    chk("R8 cycles L0", bcnt, 7);
    chk("R9 done low", {31'b0, done}, 0);
    chk("R9 busy low", {31'b0, busy}, 0);
  endtask

  task automatic t_mode1;
    setup(32'h120, 32'h220, 32'h11112222);
    run(32'h40, 32'h44, 2'd1);
    chk("R4 data", mem[8'h88], 32'h11112222);
    chk("R4 srcptr", mem[8'h10], 32'h120);
    chk("R4 dstptr", mem[8'h11], 32'h224);
    chk("R4 writes", wn, 2);
  endtask

  task automatic t_mode2;
    setup(32'h130, 32'h230, 32'h33334444);
    run(32'h40, 32'h44, 2'd2);
    chk("R5 data", mem[8'h8C], 32'h33334444);
    chk("R5 srcptr", mem[8'h10], 32'h134);
    chk("R5 dstptr", mem[8'h11], 32'h230);
    chk("R5 writes", wn, 2);
  endtask

  task automatic t_mode3;
    setup(32'h140, 32'h240, 32'h55556666);
    run(32'h40, 32'h44, 2'd3);
    chk("R6 data", mem[8'h90], 32'h55556666);
    chk("R6 srcptr", mem[8'h10], 32'h140);
    chk("R6 dstptr", mem[8'h11], 32'h240);
    chk("R6 writes", wn, 1);
  endtask

  task automatic t_wrap;
    setup(32'hFFFFFFFC, 32'h300, 32'h77778888);
    run(32'h40, 32'h44, 2'd0);
    chk("R7 data", mem[8'hC0], 32'h77778888);
    chk("R7 wrap", mem[8'h10], 32'h0);
    chk("R7 dstptr", mem[8'h11], 32'h304);
  endtask

  task automatic t_wait;
    setup(32'h150, 32'h250, 32'h9999AAAA);
    lat = 2;
    run(32'h40, 32'h44, 2'd0);
    lat = 0;
    chk("R8 data", mem[8'h94], 32'h9999AAAA);
    chk("R8 srcptr", mem[8'h10], 32'h154);
    chk("R8 stable", {31'b0, unstable}, 0);
    chk("R8 cycles L2", bcnt, 19);
  endtask

  task automatic t_busy_go;
    int n = 0;
    setup(32'h160, 32'h260, 32'hBBBBCCCC);
    put(32'h48, 32'h170); put(32'h4C, 32'h270);
    @(negedge clk); clr_log = 1;
    @(negedge clk); clr_log = 0;
    src_ref = 32'h40; dst_ref = 32'h44; mode = 2'd1; go = 1;
    @(negedge clk); go = 0;
    @(negedge clk);
    src_ref = 32'h48; dst_ref = 32'h4C; mode = 2'd3;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk("R10 idle", {31'b0, busy}, 0);
    chk("R10 writes", wn, 2);
    chk("R10 data", mem[8'h98], 32'hBBBBCCCC);
    chk("R10 other ptr", mem[8'h13], 32'h270);
    chk("R11 src kept", mem[8'h10], 32'h160);
    chk("R11 mode kept", mem[8'h11], 32'h264);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_mode0;
    t_mode1;
    t_mode2;
    t_mode3;
    t_wrap;
    t_wait;
    t_busy_go;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule